// File: doc/BRIEF.md
# Rotating Unit-Element Selector for a Multibit Current DAC

This block sits between a multibit noise-shaping modulator and an array of 32 matched unit current sources. For each modulator sample it receives a level count, the number of unit elements that must conduct. It decides which elements those are. A fixed thermometer map would always use the same low-index elements, so each element's mismatch would show up as in-band distortion. Instead, the block keeps a rotating start pointer. Each sample switches on a contiguous run of elements that begins where the previous run ended and wraps from the top index back to index 0. Every element is therefore used equally often, and the mismatch error is pushed out of band with a first-order high-pass shape.

The result is registered and delivered as an enable word together with its bitwise complement, which drive the two halves of differential current-steering cells. A valid flag accompanies each new word. Between samples the outputs hold their last value. The element count must be a power of two so that the pointer wraps naturally.

Top module: `dwa_selector`

## Requirements
- R1: After reset the enable word is all zeros, the complement word is all ones, the valid flag is low, and the rotation pointer is 0, so the first sample's run starts at bit 0.
- R2: On a sample strobe with count c in 1..31 and pointer p, the enable word registered at the next clock edge has exactly bits (p+k) mod 32 set for k = 0..c-1. Bit 31 is followed by bit 0.
- R3: After a sample with count c, the pointer becomes (p + c) mod 32, so the next run starts immediately above the last element used.
- R4: A count of 0 produces an all-zero enable word and leaves the pointer unchanged.
- R5: A count of 32 produces an all-ones enable word and leaves the pointer unchanged.
- R6: Counts from 33 to 63 are treated exactly as 32.
- R7: The complement output equals the bitwise inverse of the enable word at all times after reset.
- R8: The valid flag is high in exactly the clock cycle following a cycle in which the sample strobe was high.
- R9: While the strobe is low, the count input is ignored: the enable word, the complement word and the pointer keep their values.
- R10: Strobes on consecutive cycles are each accepted, and each one advances the pointer from the value the previous strobe left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| smp_vld | input | 1 | Sample strobe; the count is taken on a rising edge where this is high |
| lvl_cnt | input | 6 | Number of elements to enable for this sample (0..63, saturated at 32) |
| en_p | output | 32 | Element enable word, positive half |
| en_n | output | 32 | Bitwise complement of en_p for the negative half |
| out_vld | output | 1 | High for one cycle when a new word is presented |

## Verification
The only hidden state is the rotation pointer. A wrong pointer does not show in the word that updated it; it shows one sample later, as a run that starts at the wrong bit. The bench therefore keeps its own pointer model and checks the exact bit pattern of every word, including runs that wrap past bit 31. Zero, full and over-range counts are checked by the word they produce and by where the following sample's run begins. Ignored-count behaviour is checked the same way, through the word and the next run's start after strobe-low cycles with the count input toggling.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
  // Default element count of the unit-source array (must be a power of two)
  localparam int unsigned DWA_ELEMS_DEF = 32;

  // Pointer width for a given element count
  function automatic int unsigned dwa_ptr_w(input int unsigned elems);
    int unsigned w;
    w = 0;
    while ((1 << w) < elems) w++;
    return w;
  endfunction
endpackage

// File: rtl/dwa_ptr.sv
module dwa_ptr #(
  parameter int unsigned PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [PTR_W-1:0] step,
  output logic [PTR_W-1:0] ptr_q
);
  logic [PTR_W-1:0] ptr_d;

  // Modulo wrap is implicit in the PTR_W-bit addition
  always_comb begin
    ptr_d = ptr_q;
    if (adv_en) ptr_d = ptr_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R3
  ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_en |=> ptr_q == PTR_W'($past(ptr_q) + $past(step)));

  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(ptr_q));
endmodule

// File: rtl/dwa_rotmask.sv
module dwa_rotmask #(
  parameter int unsigned ELEMS = 32,
  parameter int unsigned PTR_W = 5,
  parameter int unsigned CNT_W = 6
) (
  input  logic [PTR_W-1:0] ptr,
  input  logic [CNT_W-1:0] cnt,
  output logic [ELEMS-1:0] mask
);
  // Element i is on when its distance above the pointer is below cnt
  for (genvar i = 0; i < ELEMS; i++) begin : g_elem
    logic [PTR_W-1:0] ofs;
    assign ofs     = PTR_W'(i) - ptr;
    assign mask[i] = (CNT_W'(ofs) < cnt);
  end
endmodule

// File: rtl/dwa_selector.sv
module dwa_selector
  import dwa_pkg::*;
#(
  parameter int unsigned ELEMS = DWA_ELEMS_DEF,
  localparam int unsigned PTR_W = dwa_ptr_w(ELEMS),
  localparam int unsigned CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [CNT_W-1:0] lvl_cnt,
  output logic [ELEMS-1:0] en_p,
  output logic [ELEMS-1:0] en_n,
  output logic             out_vld
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ELEMS);

  logic [CNT_W-1:0] cnt_sat;
  logic [PTR_W-1:0] ptr_q;
  logic [ELEMS-1:0] mask;
  logic [ELEMS-1:0] en_p_d, en_n_d;
  logic             vld_d;

  // Saturate over-range counts to the full array
  always_comb begin
    cnt_sat = (lvl_cnt > CNT_FULL) ? CNT_FULL : lvl_cnt;
  end

  dwa_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (smp_vld),
    .step   (cnt_sat[PTR_W-1:0]),
    .ptr_q  (ptr_q)
  );

  dwa_rotmask #(.ELEMS(ELEMS), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_mask (
    .ptr  (ptr_q),
    .cnt  (cnt_sat),
    .mask (mask)
  );

  always_comb begin
    en_p_d = en_p;
    en_n_d = en_n;
    vld_d  = smp_vld;
    if (smp_vld) begin
      en_p_d = mask;
      en_n_d = ~mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_p    <= '0;
      en_n    <= '1;
      out_vld <= 1'b0;
    end else begin
      en_p    <= en_p_d;
      en_n    <= en_n_d;
      out_vld <= vld_d;
    end
  end

  // R7
  cmpl_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n == ~en_p);

  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_vld |=> $countones(en_p) == int'($past(cnt_sat)));

  // R2
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && lvl_cnt != '0) |=> en_p[$past(ptr_q)]);

  // R8
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == $past(smp_vld));

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(en_p));
endmodule

// File: tb/tb_dwa_selector.sv
`timescale 1ns/1ps
module tb_dwa_selector;
  logic        clk;
  logic        rst_n;
  logic        smp_vld;
  logic [5:0]  lvl_cnt;
  logic [31:0] en_p;
  logic [31:0] en_n;
  logic        out_vld;

  int n_chk;
  int n_fail;
  int m_ptr;
  bit done;

  dwa_selector dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .lvl_cnt (lvl_cnt),
    .en_p    (en_p),
    .en_n    (en_n),
    .out_vld (out_vld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] exp_word(input int p, input int c);
    logic [31:0] w;
    int cs;
    cs = (c > 32) ? 32 : c;
    w = '0;
    for (int k = 0; k < cs; k++) w[(p + k) % 32] = 1'b1;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed sample, checked in the following cycle
  task automatic sample(input int c, input string req);
    logic [31:0] e;
    e = exp_word(m_ptr, c);
    @(negedge clk);
    smp_vld = 1'b1;
    lvl_cnt = 6'(c);
    @(negedge clk);
    smp_vld = 1'b0;
    chk(en_p == e, req, en_p, e);
    chk(en_n == ~e, {req, "/R7"}, en_n, ~e);
    chk(out_vld == 1'b1, {req, "/R8"}, 32'(out_vld), 32'd1);
    m_ptr = (m_ptr + ((c > 32) ? 32 : c)) % 32;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    smp_vld = 1'b0;
    lvl_cnt = '0;
    m_ptr = 0;
    repeat (3) @(negedge clk);
    chk(en_p == '0, "R1", en_p, '0);
    chk(en_n == '1, "R1", en_n, '1);
    chk(out_vld == 1'b0, "R1", 32'(out_vld), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    sample(3, "R1");
  endtask

  task automatic t_rotate;
    sample(5, "R2");
    sample(7, "R3");
    sample(12, "R2");
    sample(9, "R2 wrap");
    sample(31, "R3 wrap");
    sample(1, "R3");
  endtask

  task automatic t_zero_full;
    sample(0, "R4");
    sample(4, "R4 ptr");
    sample(32, "R5");
    sample(6, "R5 ptr");
    sample(45, "R6");
    sample(63, "R6");
    sample(2, "R6 ptr");
  endtask

  task automatic t_hold;
    logic [31:0] keep;
    keep = en_p;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lvl_cnt = 6'(k * 9 + 5);
      @(negedge clk);
      chk(en_p == keep, "R9", en_p, keep);
      chk(out_vld == 1'b0, "R8", 32'(out_vld), 32'd0);
    end
    sample(3, "R9 ptr");
  endtask

  task automatic t_b2b;
    int seq [6] = '{11, 20, 0, 17, 32, 30};
    logic [31:0] e;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      smp_vld = 1'b1;
      lvl_cnt = 6'(seq[k]);
      e = exp_word(m_ptr, seq[k]);
      m_ptr = (m_ptr + seq[k]) % 32;
      @(negedge clk);
      chk(en_p == e, "R10", en_p, e);
      chk(out_vld == 1'b1, "R10", 32'(out_vld), 32'd1);
    end
    smp_vld = 1'b0;
    @(negedge clk);
    chk(out_vld == 1'b0, "R8", 32'(out_vld), 32'd0);
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 40; k++) sample((k * 13 + 7) % 34, "R2 sweep");
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    t_reset();
    t_rotate();
    t_zero_full();
    t_hold();
    t_b2b();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule